// File: doc/BRIEF.md
# Dual-Strobe Fall-Through FIFO

A sixteen-word, four-bit first-in first-out buffer filled and drained by two independent strobe inputs rather than by enables. One system clock samples both strobes through two-flop synchronizers and finds their active edges. The load strobe rests low, and a word is taken in when it falls. The unload strobe rests high, and the read position moves on when it rises. Both the write address and the read address are one-hot ring counters. An occupancy counter beside them separates a full buffer from an empty one.

The oldest stored word is always present on the data output while the buffer holds data, so no extra read is needed to see it. Two status flags report the buffer state. Input ready means there is room and the load strobe is resting. Output ready means data is present and the unload strobe is resting. An active-low clear empties the buffer. The output-enable input releases only the data outputs.

Top module: `strobe_fifo`

## Requirements
- R1: Words leave in the order they were written, and up to 16 four-bit words can be held at once.
- R2: A high-to-low transition on `ld_stb` stores `din` at the write position when the buffer is not full. The result shows at the ports by the fourth falling clock edge after the strobe falls.
- R3: A low-to-high transition on `un_stb` discards the word at the read position when the buffer is not empty, which brings the next oldest word to `dout`.
- R4: With 16 words held, load transitions change neither the stored words nor the count.
- R5: With the buffer empty, unload transitions have no effect: a word loaded afterwards is the one presented at `dout`.
- R6: `in_rdy` is 1 exactly when fewer than 16 words are held and the synchronized `ld_stb` level is 0.
- R7: `out_rdy` is 1 exactly when at least one word is held and the synchronized `un_stb` level is 1.
- R8: Holding `clr_n` at 0 for a clock empties the buffer and returns both rings to position 0. Afterwards `out_rdy` is 0, `dout` is 0, and `in_rdy` is 1 while `ld_stb` rests low.
- R9: While `oe` is 0, `dout` is 0 and `dout_en` is 0. `in_rdy` and `out_rdy` are unaffected.
- R10: A load edge and an unload edge found in the same clock, with the buffer neither full nor empty, both take effect and leave the count unchanged.
- R11: When the buffer is not empty and `oe` is 1, `dout` shows the oldest word. When the buffer is empty, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low buffer clear |
| ld_stb | input | 1 | Load strobe, rests low, active on its falling edge |
| un_stb | input | 1 | Unload strobe, rests high, active on its rising edge |
| din | input | 4 | Word to store |
| oe | input | 1 | Output enable for the data outputs |
| dout | output | 4 | Oldest stored word, 0 when empty or disabled |
| dout_en | output | 1 | Drive enable for `dout` |
| in_rdy | output | 1 | Room available and load strobe resting |
| out_rdy | output | 1 | Data present and unload strobe resting |

## Verification
A strobe change reaches the first synchronizer flop at the next rising clock edge and the second flop at the edge after that. The second flop drives the flag qualification and the edge pulse, so the flags follow a strobe level after two rising edges. A stored or removed word shows at `dout` and in the flags after the third rising edge. The bench changes strobes on falling clock edges and holds each level for at least three clock periods. It compares results only four falling edges after a strobe returns to rest. The one exception is the flag-qualification check, which is sampled three falling edges into a held strobe.

// File: rtl/fifo_pkg.sv
// Package: shared types for the strobe FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package fifo_pkg;

    // Which transition of a strobe counts as its active edge
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_t;

endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Brings an asynchronous strobe into the clock domain through two flops
// and emits a one-cycle pulse on the chosen transition.
// Assumes: the strobe holds each level for at least two clock periods, and
// IDLE is the level the strobe rests at, so reset raises no false edge.
module strobe_edge
    import fifo_pkg::*;
#(
    parameter edge_kind_t KIND = EDGE_FALL,
    parameter logic       IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic level_o,
    output logic edge_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchronizer pair plus history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= IDLE;
            sync_q <= IDLE;
            prev_q <= IDLE;
        end else begin
            meta_q <= strobe_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;

    generate
        if (KIND == EDGE_FALL) begin : g_fall
            // Falling transition of the synchronized level
            always_comb edge_o = prev_q & ~sync_q;
        end else begin : g_rise
            // Rising transition of the synchronized level
            always_comb edge_o = ~prev_q & sync_q;
        end
    endgenerate

    // An edge pulse lasts exactly one cycle (R2, R3)
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/ring_ptr.sv
// Module: ring_ptr
// One-hot ring counter used as a FIFO address; rotates one place per advance.
// Assumes: the clear input has priority over the advance input.
module ring_ptr #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             adv,
    output logic [DEPTH-1:0] ptr_o
);

    localparam logic [DEPTH-1:0] HOME = {{(DEPTH-1){1'b0}}, 1'b1};

    logic [DEPTH-1:0] ptr_q;

    // Rotate the single hot bit toward the MSB, wrapping to bit 0
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            ptr_q <= HOME;
        end else if (adv) begin
            ptr_q <= {ptr_q[DEPTH-2:0], ptr_q[DEPTH-1]};
        end
    end

    assign ptr_o = ptr_q;

    // Exactly one position is ever selected (R1)
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ptr_q) == 1);

    // Clear returns the ring to position 0 (R8)
    p_clear_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> ptr_q == HOME);

endmodule

// File: rtl/word_store.sv
// Module: word_store
// Register-file storage with one-hot write and read selects; read is combinational.
// Assumes: wr_sel and rd_sel are one-hot; contents need no reset.
module word_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [DEPTH-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [DEPTH-1:0] rd_sel,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Write the selected word when enabled
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && wr_sel[i]) mem_q[i] <= wr_data;
        end
    end

    // AND-OR read multiplexer driven by the one-hot read select
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_data = rd_data | (mem_q[i] & {WIDTH{rd_sel[i]}});
        end
    end

endmodule

// File: rtl/strobe_fifo.sv
// Module: strobe_fifo (top)
// Fall-through FIFO filled by a falling load strobe and drained by a rising
// unload strobe, both sampled by the system clock. An occupancy counter
// distinguishes full from empty beside the one-hot address rings.
// Assumes: strobes hold each level for at least two clock periods, and din
// is stable from the load strobe's fall until three clock edges later.
module strobe_fifo
    import fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ld_stb,
    input  logic             un_stb,
    input  logic [WIDTH-1:0] din,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             in_rdy,
    output logic             out_rdy
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic             ld_lvl, ld_edge;
    logic             un_lvl, un_edge;
    logic [DEPTH-1:0] wr_ptr, rd_ptr;
    logic [WIDTH-1:0] head_word;
    logic [CW-1:0]    cnt_q;
    logic             full, empty;
    logic             wr_acc, rd_acc;

    strobe_edge #(.KIND(EDGE_FALL), .IDLE(1'b0)) u_ld_edge (
        .clk(clk), .rst_n(rst_n), .strobe_in(ld_stb),
        .level_o(ld_lvl), .edge_o(ld_edge)
    );

    strobe_edge #(.KIND(EDGE_RISE), .IDLE(1'b1)) u_un_edge (
        .clk(clk), .rst_n(rst_n), .strobe_in(un_stb),
        .level_o(un_lvl), .edge_o(un_edge)
    );

    // Accept decisions based on the occupancy before this cycle
    always_comb begin
        full   = (cnt_q == FULL_CNT);
        empty  = (cnt_q == '0);
        wr_acc = clr_n & ld_edge & ~full;
        rd_acc = clr_n & un_edge & ~empty;
    end

    ring_ptr #(.DEPTH(DEPTH)) u_wr_ring (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .adv(wr_acc), .ptr_o(wr_ptr)
    );

    ring_ptr #(.DEPTH(DEPTH)) u_rd_ring (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .adv(rd_acc), .ptr_o(rd_ptr)
    );

    word_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .wr_en(wr_acc), .wr_sel(wr_ptr), .wr_data(din),
        .rd_sel(rd_ptr), .rd_data(head_word)
    );

    // Occupancy: +1 per accepted write, -1 per accepted read
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(wr_acc) - CW'(rd_acc);
        end
    end

    // Output drive and level-qualified status flags
    always_comb begin
        dout    = (oe && !empty) ? head_word : '0;
        dout_en = oe;
        in_rdy  = ~full & ~ld_lvl;
        out_rdy = ~empty & un_lvl;
    end

    // A load edge while full changes neither count nor write ring (R4)
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && full && ld_edge && !un_edge) |=> (cnt_q == FULL_CNT) && $stable(wr_ptr));

    // An unload edge while empty changes neither count nor read ring (R5)
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && empty && un_edge && !ld_edge) |=> (cnt_q == '0) && $stable(rd_ptr));

    // Coincident edges in the middle range keep the count (R10)
    p_both_edges_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !full && !empty && ld_edge && un_edge) |=> $stable(cnt_q));

    // After a clear nothing is reported as readable (R8)
    p_clear_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !out_rdy && dout == '0);

    // Occupancy never exceeds the depth (R1)
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       ld_stb = 1'b0;
    logic       un_stb = 1'b1;
    logic [3:0] din = 4'h0;
    logic       oe = 1'b1;
    logic [3:0] dout;
    logic       dout_en, in_rdy, out_rdy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [3:0] model_q[$];

    always #4 clk = ~clk;

    strobe_fifo i_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_stb(ld_stb),
        .un_stb(un_stb), .din(din), .oe(oe), .dout(dout),
        .dout_en(dout_en), .in_rdy(in_rdy), .out_rdy(out_rdy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_dout();
        if (!oe || model_q.size() == 0) return 4'h0;
        return model_q[0];
    endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full port comparison after strobes are back at rest
    task automatic check_state(input string req);
        chk({req, " dout"}, 32'(dout), 32'(exp_dout()));
        chk({req, " in_rdy"}, 32'(in_rdy), 32'(model_q.size() < 16));
        chk({req, " out_rdy"}, 32'(out_rdy), 32'(model_q.size() > 0));
        chk({req, " dout_en"}, 32'(dout_en), 32'(oe));
    endtask

    // R2/R6: pulse load; in_rdy must drop while the strobe is high
    task automatic do_load(input logic [3:0] d);
        @(negedge clk);
        din = d;
        ld_stb = 1'b1;
        settle(3);
        chk("R6 in_rdy low during load", 32'(in_rdy), 32'd0);
        ld_stb = 1'b0;
        settle(4);
        if (model_q.size() < 16) model_q.push_back(d);
    endtask

    // R3/R7: pulse unload; out_rdy must drop while the strobe is low
    task automatic do_unload();
        @(negedge clk);
        un_stb = 1'b0;
        settle(3);
        chk("R7 out_rdy low during unload", 32'(out_rdy), 32'd0);
        un_stb = 1'b1;
        settle(4);
        if (model_q.size() > 0) void'(model_q.pop_front());
    endtask

    // R10: both strobes toggled together so both edges coincide
    task automatic do_both(input logic [3:0] d);
        int sz;
        @(negedge clk);
        din = d;
        ld_stb = 1'b1;
        un_stb = 1'b0;
        settle(3);
        ld_stb = 1'b0;
        un_stb = 1'b1;
        settle(4);
        sz = model_q.size();
        if (sz > 0) void'(model_q.pop_front());
        if (sz < 16) model_q.push_back(d);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        settle(1);
        model_q.delete();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        settle(3);
        rst_n = 1'b1;
        settle(2);
        // Reset state (R8, R11)
        check_state("R8 reset");

        // R1/R11: order of two words, fall-through
        do_load(4'hA);
        check_state("R11 fall-through");
        do_load(4'h5);
        do_unload();
        check_state("R1 order");
        do_unload();
        check_state("R3 drain");

        // R5: unload on empty, then verify head is the next loaded word
        do_unload();
        check_state("R5 empty unload");
        do_load(4'h3);
        check_state("R5 head after empty unload");

        // R10: coincident edges at count 1
        do_both(4'hC);
        check_state("R10 both edges");

        // R4: fill to 16, extra load ignored, then drain in order
        for (int i = 0; i < 15; i++) do_load(4'(i + 1));
        check_state("R4 full");
        do_load(4'hF);
        check_state("R4 load while full");
        for (int i = 0; i < 16; i++) begin
            do_unload();
            check_state("R1 drain order");
        end

        // R9: oe low releases data, flags unchanged
        do_load(4'h9);
        @(negedge clk);
        oe = 1'b0;
        settle(1);
        check_state("R9 oe low");
        chk("R9 dout released", 32'(dout), 32'd0);
        oe = 1'b1;
        settle(1);
        check_state("R9 oe high");

        // R8: clear with data present
        do_load(4'h7);
        do_clear();
        check_state("R8 clear");
        do_load(4'h2);
        check_state("R8 ring home after clear");

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 19));
            if (op < 8)       do_load(4'($urandom()));
            else if (op < 15) do_unload();
            else if (op < 18) do_both(4'($urandom()));
            else if (op < 19) do_clear();
            else begin
                @(negedge clk);
                oe = ~oe;
                settle(1);
            end
            check_state("R2 R3 random");
        end

        summary();
    end

endmodule